// File: doc/BRIEF.md
# Four-Pixel to Single-Pixel Rate Converter

This block sits between a lane-aligned video front end and an image signal processor. It receives 48-bit groups on a divided clock, one group at most every third cycle. Each group holds four 12-bit pixels together with a line-valid and a frame-valid bit. The block sends those pixels one per cycle on a separate pixel clock. That clock runs at four thirds of the input clock, so three input cycles carry the same number of pixels as four output cycles.

An asynchronous FIFO moves the groups across the clock boundary. It has Gray-coded pointers, two-flop synchronizers and eight entries. The qualifiers travel in the same FIFO entry as their pixels, so they stay aligned at the output without a separate path. Output starts once the read side sees at least two groups queued. A sticky start flag reports when the stream is running. If the FIFO runs dry partway through an active line, the converter holds the last pixel, drops line-valid and records the event in a sticky underflow flag.

Top module: `pix_rate_conv`

## Requirements
- R1: While reset is asserted, and after it is released with no data written, pix_data_o, pix_lv_o, pix_fv_o, start_o and underflow_o are all 0.
- R2: No pixel is emitted and start_o stays 0 until the FIFO holds at least two groups. start_o rises in the cycle the first pixel appears and stays high until reset.
- R3: The pixels of a group leave lowest field first: bits [11:0], then [23:12], then [35:24], then [47:36].
- R4: The four pixels of a group occupy four consecutive pixel-clock cycles. While groups are available, consecutive groups follow with no idle cycle.
- R5: The line-valid and frame-valid bits written with a group appear on pix_lv_o and pix_fv_o for exactly the four cycles that carry that group's pixels.
- R6: When no group is available at a group boundary and the last group sent had line-valid 1, pix_lv_o goes low, pix_data_o and pix_fv_o hold their values, and underflow_o is set and stays set until reset.
- R7: When the FIFO runs empty after a group whose line-valid bit was 0, pix_lv_o is 0, the data is held, and underflow_o is not set.
- R8: Every group written is emitted exactly once, in write order, with no pixel lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in_i | input | 1 | Divided input clock |
| clk_pix_i | input | 1 | Output pixel clock (4/3 of clk_in_i) |
| rst_ni | input | 1 | Asynchronous active-low reset, synchronized in each domain |
| grp_valid_i | input | 1 | Write strobe for one four-pixel group |
| grp_data_i | input | 48 | Four 12-bit pixels, lowest field sent first |
| grp_lv_i | input | 1 | Line-valid for the group |
| grp_fv_i | input | 1 | Frame-valid for the group |
| pix_data_o | output | 12 | Output pixel |
| pix_lv_o | output | 1 | Output line-valid, aligned to pix_data_o |
| pix_fv_o | output | 1 | Output frame-valid, aligned to pix_data_o |
| start_o | output | 1 | Sticky flag: output stream running |
| underflow_o | output | 1 | Sticky flag: FIFO ran empty inside an active line |

## Verification
The write-side assertion assumes the source never strobes a group while the FIFO is full. The bench respects this by running the input clock only one percent above its nominal ratio and by inserting pauses after blanking groups, so the queue stays well below eight entries. The read-side checks assume groups keep arriving during active lines. The stimulus pauses inside a line only in the dedicated underflow phase, and every stretch of normal traffic ends with blanking groups before it idles.

// File: rtl/pix_rate_conv_pkg.sv
package pix_rate_conv_pkg;
  localparam int PIX_W = 12;
  localparam int LANES = 4;
  localparam int GRP_W = PIX_W * LANES;

  typedef struct packed {
    logic             fv;
    logic             lv;
    logic [GRP_W-1:0] data;
  } grp_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sr_q[STAGES-1];
endmodule

// File: rtl/gray_sync.sv
module gray_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/async_fifo.sv
module async_fifo #(
  parameter int W      = 50,
  parameter int ADDR_W = 3
) (
  input  logic          wclk_i,
  input  logic          wrst_ni,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  output logic          wfull_o,
  input  logic          rclk_i,
  input  logic          rrst_ni,
  input  logic          rd_i,
  output logic [W-1:0]  rdata_o,
  output logic [ADDR_W:0] rlevel_o,
  output logic          rempty_o
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, wbin_nx, rgray_w;
  logic [PW-1:0] rbin_q, rgray_q, rbin_nx, wgray_r, wbin_r;
  logic          wr_ok;

  // write domain
  assign wr_ok   = wr_i && !wfull_o;
  assign wbin_nx = wbin_q + PW'(wr_ok);
  assign wfull_o = (wgray_q == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});

  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_nx;
      wgray_q <= (wbin_nx >> 1) ^ wbin_nx;
    end
  end

  always_ff @(posedge wclk_i) begin
    if (wr_ok) mem[wbin_q[ADDR_W-1:0]] <= wdata_i;
  end

  gray_sync #(.W(PW)) u_r2w (
    .clk_i (wclk_i), .rst_ni(wrst_ni), .d_i(rgray_q), .q_o(rgray_w)
  );

  // read domain
  gray_sync #(.W(PW)) u_w2r (
    .clk_i (rclk_i), .rst_ni(rrst_ni), .d_i(wgray_q), .q_o(wgray_r)
  );

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_r[i] = ^(wgray_r >> i);
  end

  assign rlevel_o = wbin_r - rbin_q;
  assign rempty_o = (rlevel_o == '0);
  assign rdata_o  = mem[rbin_q[ADDR_W-1:0]];
  assign rbin_nx  = rbin_q + PW'(rd_i && !rempty_o);

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_nx;
      rgray_q <= (rbin_nx >> 1) ^ rbin_nx;
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    wr_i |-> !wfull_o);
  // R8
  no_underread_chk: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    rd_i |-> !rempty_o);
endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
  import pix_rate_conv_pkg::*;
#(
  parameter int LVL_W     = 4,
  parameter int START_LVL = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  grp_t             head_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             empty_i,
  output logic             rd_o,
  output logic [PIX_W-1:0] pix_o,
  output logic             lv_o,
  output logic             fv_o,
  output logic             start_o,
  output logic             underflow_o
);
  localparam int CNT_W = $clog2(LANES);
  localparam int SH_W  = GRP_W - PIX_W;

  logic [CNT_W-1:0] rem_q;
  logic [SH_W-1:0]  sh_q;
  logic             line_q, started_q, go;

  assign go      = started_q || (level_i >= LVL_W'(START_LVL));
  assign rd_o    = (rem_q == '0) && go && !empty_i;
  assign start_o = started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q       <= '0;
      sh_q        <= '0;
      line_q      <= 1'b0;
      started_q   <= 1'b0;
      pix_o       <= '0;
      lv_o        <= 1'b0;
      fv_o        <= 1'b0;
      underflow_o <= 1'b0;
    end else if (rem_q != '0) begin
      pix_o <= sh_q[PIX_W-1:0];
      sh_q  <= sh_q >> PIX_W;
      rem_q <= rem_q - 1'b1;
    end else if (rd_o) begin
      pix_o     <= head_i.data[PIX_W-1:0];
      sh_q      <= head_i.data[GRP_W-1:PIX_W];
      lv_o      <= head_i.lv;
      fv_o      <= head_i.fv;
      line_q    <= head_i.lv;
      rem_q     <= CNT_W'(LANES - 1);
      started_q <= 1'b1;
    end else begin
      lv_o <= 1'b0;
      if (started_q && line_q) underflow_o <= 1'b1;
    end
  end

  // R2
  start_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> start_o);
  // R2
  no_early_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |-> (!lv_o && pix_o == '0));
  // R5
  qual_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_q != '0) |=> ($stable(lv_o) && $stable(fv_o)));
  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_q == '0 && !rd_o) |=> ($stable(pix_o) && $stable(fv_o) && !lv_o));
  // R6
  underflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);
endmodule

// File: rtl/pix_rate_conv.sv
module pix_rate_conv
  import pix_rate_conv_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int START_LVL = 2
) (
  input  logic             clk_in_i,
  input  logic             clk_pix_i,
  input  logic             rst_ni,
  input  logic             grp_valid_i,
  input  logic [GRP_W-1:0] grp_data_i,
  input  logic             grp_lv_i,
  input  logic             grp_fv_i,
  output logic [PIX_W-1:0] pix_data_o,
  output logic             pix_lv_o,
  output logic             pix_fv_o,
  output logic             start_o,
  output logic             underflow_o
);
  localparam int ENT_W = $bits(grp_t);
  localparam int LVL_W = ADDR_W + 1;

  logic             rst_in_n, rst_pix_n, wfull, rd, empty;
  logic [LVL_W-1:0] level;
  logic [ENT_W-1:0] rdata;
  grp_t             wgrp, head;

  rst_sync #(.STAGES(2)) u_rst_in  (.clk_i(clk_in_i),  .rst_ni(rst_ni), .rst_no(rst_in_n));
  rst_sync #(.STAGES(2)) u_rst_pix (.clk_i(clk_pix_i), .rst_ni(rst_ni), .rst_no(rst_pix_n));

  assign wgrp = '{fv: grp_fv_i, lv: grp_lv_i, data: grp_data_i};
  assign head = rdata;

  async_fifo #(.W(ENT_W), .ADDR_W(ADDR_W)) u_fifo (
    .wclk_i  (clk_in_i),
    .wrst_ni (rst_in_n),
    .wr_i    (grp_valid_i),
    .wdata_i (wgrp),
    .wfull_o (wfull),
    .rclk_i  (clk_pix_i),
    .rrst_ni (rst_pix_n),
    .rd_i    (rd),
    .rdata_o (rdata),
    .rlevel_o(level),
    .rempty_o(empty)
  );

  pix_serializer #(.LVL_W(LVL_W), .START_LVL(START_LVL)) u_ser (
    .clk_i      (clk_pix_i),
    .rst_ni     (rst_pix_n),
    .head_i     (head),
    .level_i    (level),
    .empty_i    (empty),
    .rd_o       (rd),
    .pix_o      (pix_data_o),
    .lv_o       (pix_lv_o),
    .fv_o       (pix_fv_o),
    .start_o    (start_o),
    .underflow_o(underflow_o)
  );

  // R8
  full_write_chk: assert property (@(posedge clk_in_i) disable iff (!rst_in_n)
    wfull |-> !grp_valid_i);
endmodule

// File: tb/tb_pix_rate_conv.sv
`timescale 1ps/1ps
module tb_pix_rate_conv;
  logic        clk_in = 0, clk_pix = 0, rst_n = 0;
  logic        grp_valid = 0, grp_lv = 0, grp_fv = 0;
  logic [47:0] grp_data = '0;
  logic [11:0] pix_data;
  logic        pix_lv, pix_fv, start, underflow;

  int checks = 0, errors = 0;
  int pix_n = 0;
  typedef struct { logic [11:0] d; logic lv; logic fv; } exp_t;
  exp_t q[$];
  logic [11:0] last_d = '0;
  logic        last_fv = 0, grp_lv_m = 0, uf_seen = 0, allow_uf = 0, mon_en = 0;
  int          idx = 0;

  always #2500 clk_pix = ~clk_pix;
  always #3300 clk_in  = ~clk_in;

  pix_rate_conv dut (
    .clk_in_i(clk_in), .clk_pix_i(clk_pix), .rst_ni(rst_n),
    .grp_valid_i(grp_valid), .grp_data_i(grp_data), .grp_lv_i(grp_lv), .grp_fv_i(grp_fv),
    .pix_data_o(pix_data), .pix_lv_o(pix_lv), .pix_fv_o(pix_fv),
    .start_o(start), .underflow_o(underflow)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic lv, input logic fv);
    logic [47:0] d;
    for (int k = 0; k < 4; k++) begin
      exp_t e;
      pix_n = (pix_n + 1) % 4096;
      d[k*12 +: 12] = 12'(pix_n);
      e.d = 12'(pix_n); e.lv = lv; e.fv = fv;
      q.push_back(e);
    end
    @(negedge clk_in);
    grp_valid = 1; grp_data = d; grp_lv = lv; grp_fv = fv;
    @(negedge clk_in);
    grp_valid = 0;
    @(negedge clk_in);
  endtask

  // reference model, compared on every pixel clock
  always @(negedge clk_pix) begin
    if (mon_en) begin
      if (pix_data != last_d) begin
        if (q.size() == 0) chk(0, "R8", "pixel with nothing queued", int'(pix_data), 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(start, "R2", "start low with pixel out", int'(start), 1);
          chk(pix_data == e.d, "R3", "pixel value/order", int'(pix_data), int'(e.d));
          chk(pix_lv == e.lv, "R5", "line-valid", int'(pix_lv), int'(e.lv));
          chk(pix_fv == e.fv, "R5", "frame-valid", int'(pix_fv), int'(e.fv));
          if (idx == 0) grp_lv_m = e.lv;
          idx = (idx + 1) % 4;
        end
        last_d  = pix_data;
        last_fv = pix_fv;
      end else if (start) begin
        chk(idx == 0, "R4", "gap inside group", idx, 0);
        chk(!pix_lv, "R6", "line-valid during hold", int'(pix_lv), 0);
        chk(pix_fv == last_fv, "R6", "frame-valid held", int'(pix_fv), int'(last_fv));
        if (grp_lv_m) begin
          chk(allow_uf, "R4", "unexpected gap inside line", 1, 0);
          uf_seen = 1;
          chk(underflow, "R6", "underflow flag", int'(underflow), 1);
        end else
          chk(underflow == uf_seen, "R7", "underflow after blanking", int'(underflow), int'(uf_seen));
      end else
        chk(pix_data == 0 && !pix_lv && !pix_fv, "R2", "output before start", int'(pix_data), 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk_pix);
    errors++;
    $display("FAIL watchdog: run did not complete actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk_pix);
    chk(pix_data == 0 && !pix_lv && !pix_fv && !start && !underflow, "R1", "outputs in reset", int'(pix_data), 0);
    rst_n = 1;
    repeat (10) @(negedge clk_pix);
    chk(pix_data == 0 && !pix_lv && !pix_fv && !start && !underflow, "R1", "outputs after reset", int'(start), 0);
    mon_en = 1;
    // one group only: must not start
    send(1'b0, 1'b1);
    repeat (20) @(negedge clk_pix);
    chk(!start, "R2", "start with one group queued", int'(start), 0);
    // three frames of short lines
    for (int f = 0; f < 3; f++) begin
      for (int l = 0; l < 6; l++) begin
        for (int g = 0; g < 8; g++) send(1'b1, 1'b1);
        send(1'b0, 1'b1);
        send(1'b0, 1'b1);
      end
      for (int g = 0; g < 3; g++) send(1'b0, 1'b0);
      repeat (40) @(negedge clk_in);
      chk(!underflow, "R7", "no underflow after blanking drain", int'(underflow), 0);
    end
    chk(q.size() == 0, "R8", "all pixels delivered", q.size(), 0);
    // starve inside an active line
    allow_uf = 1;
    for (int g = 0; g < 5; g++) send(1'b1, 1'b1);
    repeat (60) @(negedge clk_pix);
    chk(underflow, "R6", "sticky underflow", int'(underflow), 1);
    chk(!pix_lv && pix_fv, "R6", "qualifiers in starvation", int'(pix_lv), 0);
    chk(q.size() == 0, "R8", "all pixels delivered", q.size(), 0);
    // reset clears everything
    mon_en = 0;
    @(negedge clk_pix);
    rst_n = 0;
    repeat (4) @(negedge clk_pix);
    chk(pix_data == 0 && !pix_lv && !pix_fv && !start && !underflow, "R1", "outputs on second reset", int'(underflow), 0);
    rst_n = 1;
    repeat (10) @(negedge clk_pix);
    chk(!start && !underflow, "R1", "flags after second reset", int'(start), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule